// File: doc/BRIEF.md
# Numerically Controlled Oscillator Phase Core

This block is the digital heart of a direct-synthesis frequency source. A phase accumulator advances by a programmable step on every reference clock edge and wraps modulo two to the accumulator width. The output frequency is therefore the step times the clock rate divided by that modulus. A coarse phase offset is added on top of the accumulated phase, and the sum is cut down to a short phase word with a valid strobe. A later lookup stage turns that word into an amplitude.

Settings arrive from a loader that runs on its own clock. The loader holds a tuning step, an offset code and a sleep flag steady, then raises a commit strobe. The core brings the strobe into the reference domain and takes the settings on the strobe's rising edge. It then delays the step and the offset by separate amounts, so that each change reaches the output at a fixed and known number of reference clocks. Retuning never clears the accumulator, so the output phase stays continuous. The sleep flag freezes the accumulator and the output. A synchronous reset returns everything to phase zero.

Top module: `nco_phase_core`

## Requirements
- R1: While `rst` is high at a clock edge, `phase_word` becomes 0 and `phase_valid` becomes 0 after that edge. The tuning step, the offset, the sleep flag and any pending commit are cleared, so after release the word stays at 0 until a new commit takes effect.
- R2: Each running edge adds the tuning step into a 32-bit accumulator. `phase_word` after edge n is bits [31:18] of the sum of the accumulator before edge n and the offset term.
- R3: The 5-bit offset code is added at accumulator bits [31:27], so its bits weigh 180, 90, 45, 22.5 and 11.25 degrees. With a zero step, code 5'b10000 gives `phase_word` 14'h2000 and code 5'b00001 gives 14'h0200.
- R4: The accumulator and the offset sum wrap modulo 2^32 with no saturation.
- R5: The edge E0 is the first edge at which `load_strobe` is sampled high after being sampled low. A committed tuning step is first added at edge E0+17, so the first `phase_word` to show it appears after edge E0+18.
- R6: A committed offset code is first used for `phase_word` at edge E0+13.
- R7: A commit never resets or reloads the accumulator, so the phase carries on from its current value across any retune.
- R8: The committed sleep flag takes effect at edge E0+13, on the same path as the offset. While it is set, the accumulator and `phase_word` hold their values and `phase_valid` is 0. A later commit that clears the flag resumes accumulation from the frozen value.
- R9: Settings are taken once per strobe rising edge. Holding `load_strobe` high does not commit again, and changes to the setting inputs made after the capture, while the strobe is still high, have no effect.
- R10: When the core is out of reset and not asleep, `phase_valid` is 1 after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high master reset |
| load_strobe | input | 1 | Commit strobe from the loader's clock domain |
| load_ftw | input | 32 | Tuning step, held stable by the loader around the commit |
| load_poff | input | 5 | Coarse phase offset code |
| load_pdn | input | 1 | Sleep flag |
| phase_word | output | 14 | Truncated output phase |
| phase_valid | output | 1 | High while the core produces a fresh phase each edge |

## Verification
The hardest situations to reach are the exact edges at which a committed step and a committed offset first appear. They come from one strobe edge but land five clocks apart. The bench reaches them by starting from a zero step, so the output is flat and any single-count move can be tied to one edge. It then samples the edges just before and just after each expected latency. A reference model in the bench also follows every clock: it schedules each commit's effects from the observed strobe edge, covers sleep entry and exit, and covers word changes made while the strobe is still high.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Number of flops that bring the commit strobe into the reference domain.
  localparam int unsigned NCO_SYNC_STAGES = 2;

  // Pipeline depth left after the fixed register stages are taken out of a latency.
  function automatic int unsigned nco_pipe_depth(input int unsigned lat,
                                                 input int unsigned fixed_regs);
    return lat - fixed_regs;
  endfunction
endpackage

// File: rtl/nco_commit_sync.sv
module nco_commit_sync #(
  parameter int unsigned SYNC_N = 2,
  parameter int unsigned FTW_W  = 32,
  parameter int unsigned OFF_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_async,
  input  logic [FTW_W-1:0] ftw_in,
  input  logic [OFF_W-1:0] poff_in,
  input  logic             pdn_in,
  output logic             cap_pulse,
  output logic [FTW_W-1:0] cap_ftw,
  output logic [OFF_W-1:0] cap_poff,
  output logic             cap_pdn
);
  logic [SYNC_N-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], strobe_async};
      last_q <= sync_q[SYNC_N-1];
    end
  end

  assign cap_pulse = sync_q[SYNC_N-1] & ~last_q;

  // Settings are sampled once, on the detected rising edge of the strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_ftw  <= '0;
      cap_poff <= '0;
      cap_pdn  <= 1'b0;
    end else if (cap_pulse) begin
      cap_ftw  <= ftw_in;
      cap_poff <= poff_in;
      cap_pdn  <= pdn_in;
    end
  end
endmodule

// File: rtl/nco_delay_line.sv
module nco_delay_line #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned OUT_W = 14,
  parameter int unsigned OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step,
  input  logic [OFF_W-1:0] offset,
  input  logic             sleep,
  output logic [OUT_W-1:0] phase_q,
  output logic             valid_q
);
  localparam int unsigned PAD_W = ACC_W - OFF_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] shifted;

  assign shifted = acc_q + {offset, {PAD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      phase_q <= '0;
      valid_q <= 1'b0;
    end else if (!sleep) begin
      acc_q   <= acc_q + step;
      phase_q <= shifted[ACC_W-1 -: OUT_W];
      valid_q <= 1'b1;
    end else begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core #(
  parameter int unsigned ACC_W     = 32,
  parameter int unsigned OUT_W     = 14,
  parameter int unsigned OFF_W     = 5,
  parameter int unsigned FREQ_LAT  = 18,
  parameter int unsigned PHASE_LAT = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_strobe,
  input  logic [ACC_W-1:0] load_ftw,
  input  logic [OFF_W-1:0] load_poff,
  input  logic             load_pdn,
  output logic [OUT_W-1:0] phase_word,
  output logic             phase_valid
);
  localparam int unsigned SYNC_N = nco_pkg::NCO_SYNC_STAGES;
  // Step path: capture stage plus accumulator and output registers.
  localparam int unsigned FREQ_DEPTH  = nco_pkg::nco_pipe_depth(FREQ_LAT, SYNC_N + 2);
  // Offset path: capture stage plus output register.
  localparam int unsigned PHASE_DEPTH = nco_pkg::nco_pipe_depth(PHASE_LAT, SYNC_N + 1);
  localparam int unsigned PW = OFF_W + 1;

  logic             cap_pulse;
  logic [ACC_W-1:0] cap_ftw;
  logic [OFF_W-1:0] cap_poff;
  logic             cap_pdn;
  logic [ACC_W-1:0] ftw_eff;
  logic [PW-1:0]    ph_eff;
  logic [OFF_W-1:0] poff_eff;
  logic             pdn_eff;

  nco_commit_sync #(.SYNC_N(SYNC_N), .FTW_W(ACC_W), .OFF_W(OFF_W)) u_sync (
    .clk(clk), .rst(rst), .strobe_async(load_strobe),
    .ftw_in(load_ftw), .poff_in(load_poff), .pdn_in(load_pdn),
    .cap_pulse(cap_pulse), .cap_ftw(cap_ftw), .cap_poff(cap_poff), .cap_pdn(cap_pdn)
  );

  nco_delay_line #(.W(ACC_W), .DEPTH(FREQ_DEPTH)) u_freq_dly (
    .clk(clk), .rst(rst), .d(cap_ftw), .q(ftw_eff)
  );

  nco_delay_line #(.W(PW), .DEPTH(PHASE_DEPTH)) u_phase_dly (
    .clk(clk), .rst(rst), .d({cap_pdn, cap_poff}), .q(ph_eff)
  );

  assign poff_eff = ph_eff[OFF_W-1:0];
  assign pdn_eff  = ph_eff[OFF_W];

  nco_accum #(.ACC_W(ACC_W), .OUT_W(OUT_W), .OFF_W(OFF_W)) u_acc (
    .clk(clk), .rst(rst), .step(ftw_eff), .offset(poff_eff), .sleep(pdn_eff),
    .phase_q(phase_word), .valid_q(phase_valid)
  );
endmodule

// File: rtl/nco_phase_core_chk.sv
module nco_phase_core_chk #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned OUT_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic [OUT_W-1:0] phase_word,
  input logic             phase_valid,
  input logic             pdn_eff,
  input logic             cap_pulse,
  input logic [ACC_W-1:0] cap_ftw
);
  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (phase_word == '0) && !phase_valid); // R1

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    pdn_eff |=> $stable(phase_word) && !phase_valid); // R8

  AST_RUN_VALID: assert property (@(posedge clk) disable iff (rst)
    !pdn_eff |=> phase_valid); // R10

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    cap_pulse |=> !cap_pulse); // R9

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap_pulse |=> $stable(cap_ftw)); // R9
endmodule

bind nco_phase_core nco_phase_core_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .phase_word(phase_word), .phase_valid(phase_valid),
  .pdn_eff(pdn_eff), .cap_pulse(cap_pulse), .cap_ftw(cap_ftw)
);

// File: tb/nco_phase_core_tb.sv
module nco_phase_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_strobe = 1'b0;
  logic [31:0] load_ftw = '0;
  logic [4:0]  load_poff = '0;
  logic        load_pdn = 1'b0;
  logic [13:0] phase_word;
  logic        phase_valid;

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string sec = "R1";

  // Reference model state.
  logic [31:0] m_acc = '0, m_ftw = '0, f_val = '0, sum;
  logic [4:0]  m_poff = '0, p_val = '0;
  logic        m_pdn = 1'b0, p_pdn = 1'b0, m_prev = 1'b0, m_vld = 1'b0;
  logic [13:0] m_out = '0;
  int          f_at = -1, p_at = -1, last_e0 = 0;

  always #2.5 clk = ~clk;

  nco_phase_core u_dut (
    .clk(clk), .rst(rst), .load_strobe(load_strobe), .load_ftw(load_ftw),
    .load_poff(load_poff), .load_pdn(load_pdn),
    .phase_word(phase_word), .phase_valid(phase_valid)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_acc = '0; m_out = '0; m_vld = 1'b0; m_ftw = '0; m_poff = '0; m_pdn = 1'b0;
      f_at = -1; p_at = -1; m_prev = 1'b0;
    end else begin
      if (!m_pdn) begin
        sum   = m_acc + {m_poff, 27'b0};
        m_out = sum[31:18];
        m_acc = m_acc + m_ftw;
        m_vld = 1'b1;
      end else begin
        m_vld = 1'b0;
      end
      if (f_at == cyc) m_ftw = f_val;
      if (p_at == cyc) begin m_poff = p_val; m_pdn = p_pdn; end
      if (load_strobe && !m_prev) begin
        last_e0 = cyc;
        f_at = cyc + 16; f_val = load_ftw;
        p_at = cyc + 12; p_val = load_poff; p_pdn = load_pdn;
      end
      m_prev = load_strobe;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({sec, " word"}, {18'b0, phase_word}, {18'b0, m_out});
      chk({sec, " valid"}, {31'b0, phase_valid}, {31'b0, m_vld});
    end
  end

  task automatic wait_to(input int n);
    do @(negedge clk); while (cyc < n);
  endtask

  task automatic commit(input logic [31:0] f, input logic [4:0] p, input logic s,
                        input bit alter, output int e0);
    @(negedge clk);
    load_ftw = f; load_poff = p; load_pdn = s; load_strobe = 1'b1;
    e0 = cyc + 1;
    repeat (4) @(negedge clk);
    if (alter) begin
      load_ftw = ~f; load_poff = ~p; load_pdn = ~s;
    end
    repeat (3) @(negedge clk);
    load_strobe = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int e0;
    logic [13:0] base;
    repeat (6) @(negedge clk);
    chk("R1 reset word", {18'b0, phase_word}, 32'h0);
    chk("R1 reset valid", {31'b0, phase_valid}, 32'h0);
    cmp_on = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 cleared after release", {18'b0, phase_word}, 32'h0);

    sec = "R3";
    commit(32'h0, 5'b10000, 1'b0, 1'b0, e0);
    wait_to(e0 + 20);
    chk("R3 offset 180deg", {18'b0, phase_word}, 32'h2000);

    sec = "R6";
    commit(32'h0, 5'b00001, 1'b0, 1'b0, e0);
    wait_to(e0 + 12);
    chk("R6 before latency", {18'b0, phase_word}, 32'h2000);
    wait_to(e0 + 13);
    chk("R6 at latency (R3 11.25deg)", {18'b0, phase_word}, 32'h0200);

    sec = "R5";
    commit(32'h0004_0000, 5'b00001, 1'b0, 1'b0, e0);
    wait_to(e0 + 16);
    base = phase_word;
    wait_to(e0 + 17);
    chk("R5 edge 17 unchanged", {18'b0, phase_word}, {18'b0, base});
    wait_to(e0 + 18);
    chk("R5 edge 18 moved", {18'b0, phase_word}, {18'b0, base + 14'd1});

    sec = "R4";
    commit(32'h9E37_79B9, 5'b01010, 1'b0, 1'b0, e0);
    wait_to(e0 + 120);

    sec = "R7";
    commit(32'h0123_4567, 5'b00111, 1'b0, 1'b0, e0);
    wait_to(e0 + 40);
    commit(32'hF000_0001, 5'b11111, 1'b0, 1'b0, e0);
    wait_to(e0 + 40);

    sec = "R8";
    commit(32'h0123_4567, 5'b00011, 1'b1, 1'b0, e0);
    wait_to(e0 + 14);
    base = phase_word;
    wait_to(e0 + 30);
    chk("R8 frozen word", {18'b0, phase_word}, {18'b0, base});
    chk("R8 valid low", {31'b0, phase_valid}, 32'h0);
    commit(32'h0123_4567, 5'b00011, 1'b0, 1'b0, e0);
    wait_to(e0 + 14);
    chk("R10 valid back", {31'b0, phase_valid}, 32'h1);
    wait_to(e0 + 30);

    sec = "R9";
    commit(32'h0200_0000, 5'b00000, 1'b0, 1'b1, e0);
    wait_to(e0 + 40);
    chk("R9 single commit", last_e0, e0);

    sec = "R2";
    commit(32'h0000_1000, 5'b00100, 1'b0, 1'b0, e0);
    wait_to(e0 + 60);

    sec = "R1";
    @(negedge clk); rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 mid-run word", {18'b0, phase_word}, 32'h0);
    @(negedge clk); rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1 stays zero", {18'b0, phase_word}, 32'h0);

    done = 1'b1;
    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule